// File: doc/BRIEF.md
# Power-Off Broadcast Aggregator

This block sits in a multi-port switch and handles a request to shut power off that arrives on the upstream port. It forwards the request as a one-cycle strobe to every downstream port that is active at that moment. It then waits for each of those ports to resolve, either through an acknowledgement or through the port's own timer running out. When the last active port has resolved, the block sends one acknowledgement pulse upstream and marks the upstream link as ready for power removal.

Each downstream port has its own programmable timeout, so a port that never answers cannot stall the sequence. A port that reaches its timeout is treated the same as one that acknowledged: its link is marked ready for power removal and it counts toward completion. Wake-event messages are turned off while a sequence is running. If the device later comes back to the uninitialized full-power state instead of losing power, the block drops every per-port and upstream status and turns wake-event messages back on.

Top module: `pm_turnoff_agg`

## Requirements
- R1: A power-off request accepted while idle produces, one cycle later, a single-cycle `dn_bcast_o` pulse equal to `port_active_i` as sampled with the request, with no bit set for an inactive port.
- R2: `up_ack_o` is a single-cycle pulse. It goes high in the cycle after the edge on which the last outstanding port resolves. When no port was active, it goes high in the cycle right after the broadcast cycle.
- R3: `up_link_rdy_o` rises together with `up_ack_o` and stays high until a return to the uninitialized state or a reset.
- R4: Port i's timeout value sits in `tmo_val_i[i*TMO_W +: TMO_W]`. With value V and no acknowledgement, the port resolves so that `dn_link_rdy_o[i]` rises V+1 cycles after the broadcast cycle. A value of zero resolves it in the cycle after the broadcast.
- R5: A `dn_ack_i[i]` seen in the broadcast cycle or later, on a port that is still pending, raises `dn_link_rdy_o[i]` in the next cycle. An acknowledgement that lands in the same cycle as timer expiry resolves the port only once.
- R6: Acknowledgements on ports that were inactive at broadcast, and acknowledgements outside a running sequence, change no output.
- R7: The active set is latched at broadcast. Later changes to `port_active_i` do not change which ports the sequence waits for.
- R8: A power-off request that arrives while a sequence is running, or after one has completed, produces no broadcast until the block returns to idle.
- R9: `wake_msg_en_o` is high after reset. It goes low in the broadcast cycle and goes high again together with `up_ack_o`.
- R10: When `dev_uninit_i` is high, the next cycle shows every `dn_link_rdy_o` bit and `up_link_rdy_o` low, `wake_msg_en_o` high, and the sequence abandoned. It takes priority over a request in the same cycle.
- R11: Synchronous reset clears all strobes and link indications and sets `wake_msg_en_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| off_req_i | input | 1 | Power-off message received on the upstream port (strobe) |
| dn_ack_i | input | NPORTS | Per-port acknowledgement received (strobe) |
| port_active_i | input | NPORTS | Downstream ports currently active |
| tmo_val_i | input | NPORTS*TMO_W | Per-port timeout values, port i at bits i*TMO_W and up |
| dev_uninit_i | input | 1 | Device returned to the uninitialized full-power state |
| dn_bcast_o | output | NPORTS | Per-port forwarded power-off strobe |
| up_ack_o | output | 1 | Upstream acknowledgement pulse |
| up_link_rdy_o | output | 1 | Upstream link in the ready-for-power-removal state |
| dn_link_rdy_o | output | NPORTS | Per-port link in the ready-for-power-removal state |
| wake_msg_en_o | output | 1 | Wake-event message generation enabled |

## Verification
The bench builds the block with four ports and a 4-bit timeout field. That keeps the full timeout range, from zero up to fifteen cycles, within a short run, so every port can expire alone, in a staggered order, or in the same cycle as its acknowledgement. Four ports give enough room for mixed active masks, including an empty one, and for random interleavings of acknowledgements, request repeats and returns to the uninitialized state during every phase of the sequence.

// File: rtl/pm_agg_pkg.sv
package pm_agg_pkg;

  // Sequence phases of the power-off aggregation
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_WAIT = 2'd1,
    SEQ_DONE = 2'd2
  } seq_st_t;

endpackage

// File: rtl/pm_port_slot.sv
// One downstream port: latched membership, countdown timer, link state.
module pm_port_slot #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             start,
  input  logic             arm,
  input  logic [TMO_W-1:0] tmo,
  input  logic             ack,
  output logic             pend_o,
  output logic             pend_nxt_o,
  output logic             link_rdy_o
);

  logic [TMO_W-1:0] cnt_q;
  logic             pend_q;
  logic             link_q;
  logic             expired;
  logic             resolve;

  assign expired = (cnt_q == '0);
  // An ack and an expiry in the same cycle collapse into one resolve
  assign resolve = pend_q & (ack | expired);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      link_q <= 1'b0;
    end else if (start) begin
      pend_q <= arm;
      cnt_q  <= tmo;
      link_q <= 1'b0;
    end else if (pend_q) begin
      if (resolve) begin
        pend_q <= 1'b0;
        link_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign pend_o     = pend_q;
  assign pend_nxt_o = pend_q & ~resolve;
  assign link_rdy_o = link_q;

endmodule

// File: rtl/pm_seq_ctrl.sv
// Sequence control: accepts the request, drives broadcast, upstream ack,
// upstream link state and wake-event enable.
module pm_seq_ctrl
  import pm_agg_pkg::*;
#(
  parameter int NPORTS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              req,
  input  logic [NPORTS-1:0] active,
  input  logic              all_clear,
  output logic              start_o,
  output logic [NPORTS-1:0] bcast_o,
  output logic              up_ack_o,
  output logic              up_link_o,
  output logic              wake_o
);

  seq_st_t st_q;

  assign start_o = (st_q == SEQ_IDLE) && req && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SEQ_IDLE;
      bcast_o   <= '0;
      up_ack_o  <= 1'b0;
      up_link_o <= 1'b0;
      wake_o    <= 1'b1;
    end else begin
      bcast_o  <= '0;
      up_ack_o <= 1'b0;
      if (clr) begin
        st_q      <= SEQ_IDLE;
        up_link_o <= 1'b0;
        wake_o    <= 1'b1;
      end else begin
        unique case (st_q)
          SEQ_IDLE: begin
            if (req) begin
              st_q    <= SEQ_WAIT;
              bcast_o <= active;
              wake_o  <= 1'b0;
            end
          end
          SEQ_WAIT: begin
            if (all_clear) begin
              st_q      <= SEQ_DONE;
              up_ack_o  <= 1'b1;
              up_link_o <= 1'b1;
              wake_o    <= 1'b1;
            end
          end
          SEQ_DONE: st_q <= SEQ_DONE;
          default:  st_q <= SEQ_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/pm_turnoff_agg.sv
module pm_turnoff_agg #(
  parameter int NPORTS = 8,
  parameter int TMO_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    off_req_i,
  input  logic [NPORTS-1:0]       dn_ack_i,
  input  logic [NPORTS-1:0]       port_active_i,
  input  logic [NPORTS*TMO_W-1:0] tmo_val_i,
  input  logic                    dev_uninit_i,
  output logic [NPORTS-1:0]       dn_bcast_o,
  output logic                    up_ack_o,
  output logic                    up_link_rdy_o,
  output logic [NPORTS-1:0]       dn_link_rdy_o,
  output logic                    wake_msg_en_o
);

  localparam int TOT_W = NPORTS * TMO_W;

  logic              start;
  logic [NPORTS-1:0] pend;
  logic [NPORTS-1:0] pend_nxt;
  logic              all_clear;

  assign all_clear = ~|pend_nxt;

  pm_seq_ctrl #(.NPORTS(NPORTS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .clr       (dev_uninit_i),
    .req       (off_req_i),
    .active    (port_active_i),
    .all_clear (all_clear),
    .start_o   (start),
    .bcast_o   (dn_bcast_o),
    .up_ack_o  (up_ack_o),
    .up_link_o (up_link_rdy_o),
    .wake_o    (wake_msg_en_o)
  );

  for (genvar gi = 0; gi < NPORTS; gi++) begin : g_port
    logic [TMO_W-1:0] tmo_slice;
    assign tmo_slice = tmo_val_i[gi*TMO_W +: TMO_W];

    pm_port_slot #(.TMO_W(TMO_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .clr        (dev_uninit_i),
      .start      (start),
      .arm        (port_active_i[gi]),
      .tmo        (tmo_slice),
      .ack        (dn_ack_i[gi]),
      .pend_o     (pend[gi]),
      .pend_nxt_o (pend_nxt[gi]),
      .link_rdy_o (dn_link_rdy_o[gi])
    );
  end

  logic unused_tot;
  assign unused_tot = (TOT_W == 0) & |pend;

endmodule

// File: rtl/pm_agg_chk.sv
module pm_agg_chk #(
  parameter int NPORTS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              dev_uninit_i,
  input logic [NPORTS-1:0] port_active_i,
  input logic [NPORTS-1:0] dn_bcast_o,
  input logic              up_ack_o,
  input logic              up_link_rdy_o,
  input logic [NPORTS-1:0] dn_link_rdy_o,
  input logic              wake_msg_en_o
);

  p_bcast_active_only_r1: assert property (@(posedge clk) disable iff (rst)
    (|dn_bcast_o) |-> ((dn_bcast_o & ~$past(port_active_i)) == '0));

  p_ack_single_r2: assert property (@(posedge clk) disable iff (rst)
    up_ack_o |=> !up_ack_o);

  p_link_with_ack_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(up_link_rdy_o) |-> up_ack_o);

  p_wake_off_bcast_r9: assert property (@(posedge clk) disable iff (rst)
    (|dn_bcast_o) |-> !wake_msg_en_o);

  p_uninit_clears_r10: assert property (@(posedge clk) disable iff (rst)
    dev_uninit_i |=> (wake_msg_en_o && !up_link_rdy_o && dn_link_rdy_o == '0
                      && dn_bcast_o == '0));

endmodule

bind pm_turnoff_agg pm_agg_chk #(.NPORTS(NPORTS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .dev_uninit_i  (dev_uninit_i),
  .port_active_i (port_active_i),
  .dn_bcast_o    (dn_bcast_o),
  .up_ack_o      (up_ack_o),
  .up_link_rdy_o (up_link_rdy_o),
  .dn_link_rdy_o (dn_link_rdy_o),
  .wake_msg_en_o (wake_msg_en_o)
);

// File: tb/pm_turnoff_agg_test.sv
module pm_turnoff_agg_test;

  localparam int NP = 4;
  localparam int TW = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            off_req = 1'b0;
  logic [NP-1:0]   ack = '0;
  logic [NP-1:0]   act = '0;
  logic [NP*TW-1:0] tmo = '0;
  logic            uninit = 1'b0;
  logic [NP-1:0]   bcast;
  logic            up_ack;
  logic            up_link;
  logic [NP-1:0]   dn_link;
  logic            wake;

  always #5 clk = ~clk;

  pm_turnoff_agg #(.NPORTS(NP), .TMO_W(TW)) uut (
    .clk(clk), .rst(rst), .off_req_i(off_req), .dn_ack_i(ack),
    .port_active_i(act), .tmo_val_i(tmo), .dev_uninit_i(uninit),
    .dn_bcast_o(bcast), .up_ack_o(up_ack), .up_link_rdy_o(up_link),
    .dn_link_rdy_o(dn_link), .wake_msg_en_o(wake)
  );

  // Behavioural reference model
  int   phase;          // 0 idle, 1 waiting, 2 complete
  int   left_cnt [NP];
  bit   waiting  [NP];
  bit   e_link   [NP];
  bit   e_bcast  [NP];
  bit   e_ack, e_up, e_wake;

  int   compared = 0;
  int   mismatched = 0;
  int   cycles = 0;
  string cur_req = "R11";

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      phase = 0; e_ack = 0; e_up = 0; e_wake = 1;
      for (int i = 0; i < NP; i++) begin
        waiting[i] = 0; e_link[i] = 0; e_bcast[i] = 0; left_cnt[i] = 0;
      end
    end else begin
      e_ack = 0;
      for (int i = 0; i < NP; i++) e_bcast[i] = 0;
      if (uninit) begin
        phase = 0; e_up = 0; e_wake = 1;
        for (int i = 0; i < NP; i++) begin waiting[i] = 0; e_link[i] = 0; end
      end else if (phase == 0) begin
        if (off_req) begin
          phase = 1; e_wake = 0;
          for (int i = 0; i < NP; i++) begin
            waiting[i] = act[i]; e_bcast[i] = act[i]; e_link[i] = 0;
            left_cnt[i] = int'(tmo[i*TW +: TW]);
          end
        end
      end else if (phase == 1) begin
        int open_cnt;
        open_cnt = 0;
        for (int i = 0; i < NP; i++) begin
          if (waiting[i]) begin
            if (ack[i] || left_cnt[i] == 0) begin
              waiting[i] = 0; e_link[i] = 1;
            end else begin
              left_cnt[i] = left_cnt[i] - 1;
              open_cnt++;
            end
          end
        end
        if (open_cnt == 0) begin
          e_ack = 1; e_up = 1; e_wake = 1; phase = 2;
        end
      end
    end
  end

  task automatic cmp(input string what, input int actual, input int expect_v);
    compared++;
    if (actual != expect_v) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, what,
               actual, expect_v, $time);
    end
  endtask

  always @(negedge clk) begin
    int eb, el;
    eb = 0; el = 0;
    for (int i = 0; i < NP; i++) begin
      eb |= int'(e_bcast[i]) << i;
      el |= int'(e_link[i]) << i;
    end
    cmp("dn_bcast", int'(bcast), eb);
    cmp("up_ack", int'(up_ack), int'(e_ack));
    cmp("up_link", int'(up_link), int'(e_up));
    cmp("dn_link", int'(dn_link), el);
    cmp("wake_en", int'(wake), int'(e_wake));
  end

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_req();
    off_req = 1'b1; tick(1); off_req = 1'b0;
  endtask

  task automatic pulse_ack(input logic [NP-1:0] m);
    ack = m; tick(1); ack = '0;
  endtask

  task automatic pulse_uninit();
    uninit = 1'b1; tick(1); uninit = 1'b0;
  endtask

  function automatic logic [NP*TW-1:0] pack4(input int a, b, c, d);
    return {TW'(d), TW'(c), TW'(b), TW'(a)};
  endfunction

  initial begin
    // R11: reset state
    cur_req = "R11";
    tick(3);
    rst = 1'b0;
    tick(2);

    // R1, R2, R5, R6: mixed mask, acks in order, ack on inactive port
    cur_req = "R1";
    act = 4'b1011; tmo = pack4(15, 15, 15, 15);
    pulse_req(); tick(1);
    cur_req = "R5";
    pulse_ack(4'b0001); tick(1);
    cur_req = "R6";
    pulse_ack(4'b0100); tick(1);
    cur_req = "R2";
    pulse_ack(4'b1010); tick(3);

    // R8: request after completion ignored; R3 link holds
    cur_req = "R8";
    pulse_req(); tick(3);
    cur_req = "R3";
    tick(2);
    cur_req = "R10";
    pulse_uninit(); tick(2);

    // R4: staggered timeouts including zero
    cur_req = "R4";
    act = 4'b1111; tmo = pack4(0, 1, 3, 7);
    pulse_req(); tick(12);
    pulse_uninit(); tick(1);

    // R5: ack in the same cycle as expiry
    cur_req = "R5";
    act = 4'b0001; tmo = pack4(2, 0, 0, 0);
    pulse_req(); tick(2);
    pulse_ack(4'b0001); tick(3);
    pulse_uninit();

    // R7: mask changes mid-sequence; R8: request while waiting
    cur_req = "R7";
    act = 4'b0011; tmo = pack4(9, 9, 9, 9);
    pulse_req();
    act = 4'b1111;
    cur_req = "R8";
    pulse_req(); tick(2);
    cur_req = "R7";
    pulse_ack(4'b1100); tick(1);
    pulse_ack(4'b0011); tick(2);
    pulse_uninit();

    // R2: empty mask completes straight after broadcast
    cur_req = "R2";
    act = 4'b0000;
    pulse_req(); tick(3);
    pulse_uninit();

    // R6: acks while idle
    cur_req = "R6";
    pulse_ack(4'b1111); tick(2);

    // R10: uninit mid-sequence, and together with a request
    cur_req = "R10";
    act = 4'b1111; tmo = pack4(10, 10, 10, 10);
    pulse_req(); tick(2);
    pulse_uninit(); tick(1);
    off_req = 1'b1; uninit = 1'b1; tick(1);
    off_req = 1'b0; uninit = 1'b0; tick(2);

    // R9: wake enable across a full sequence
    cur_req = "R9";
    act = 4'b0110; tmo = pack4(3, 3, 3, 3);
    pulse_req(); tick(8);
    pulse_uninit(); tick(1);

    // R1: random interleavings
    cur_req = "R1";
    for (int n = 0; n < 3000; n++) begin
      off_req = ($urandom_range(0, 5) == 0);
      ack     = NP'($urandom);
      act     = NP'($urandom);
      tmo     = (NP*TW)'($urandom);
      uninit  = ($urandom_range(0, 40) == 0);
      tick(1);
    end
    off_req = 1'b0; ack = '0; uninit = 1'b0;
    tick(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    wait (cycles > 50000);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule